// File: doc/BRIEF.md
# Staged Cross-Channel Stereo Attenuator

This block feeds a stream of signed stereo sample pairs through a 2x2 gain matrix. Each output channel is the sum of its own input and the opposite input, each weighted by an unsigned 8-bit gain. A gain of 0x80 passes a sample through unchanged. The result is shifted down by seven bits and clipped to the signed 16-bit range. Outputs are registered, so each result appears one cycle after its input.

The gains are double buffered. Software writes any of the four gains into a pending copy through an indexed write port. The mixer keeps using the active copy. A write to the control slot with the apply bit set moves all four pending gains into the active set on one clock edge, so no sample is ever mixed with a mix of old and new gains. The apply bit is a one-cycle command and is never stored. The same control write also sets or clears a mute flag, which forces both outputs to zero.

Top module: `xmix_atten`

## Requirements
- R1: While reset is asserted, and on the first output after reset, the block behaves as a pass-through. out_valid is 0 and both outputs are 0 during reset. The active and pending gains reset to 0x80 on the straight paths and 0x00 on the cross paths. Mute is off.
- R2: A write to a gain slot changes only that slot's pending gain. Samples keep being mixed with the previous active gains until an apply occurs.
- R3: A write to control slot 4 with bit 5 set copies all four pending gains into the active set on one edge. Bit 5 is not stored, so a later control write with bit 5 clear re-applies nothing.
- R4: The gain slots are indexed as follows: 0 scales left into left, 1 scales left into right, 2 scales right into right, 3 scales right into left. A write to index 5, 6 or 7 changes nothing.
- R5: The outputs are computed as follows, with gains taken as unsigned: out_left = floor((left*g0 + right*g3) / 128) and out_right = floor((right*g2 + left*g1) / 128). Rounding is toward minus infinity.
- R6: A result above 32767 is clipped to 32767, and a result below -32768 is clipped to -32768.
- R7: While control bit 0 (mute) is 1, every accepted sample produces 0 on both outputs. out_valid still asserts for that sample.
- R8: Control bits 7, 6, 4, 3, 2 and 1 are ignored. A control write of 0xDE neither applies nor mutes.
- R9: Each accepted sample produces out_valid = 1 in the next cycle. In a cycle with no sample, the next cycle has out_valid = 0 and both outputs hold their previous values.
- R10: A control write (apply or mute change) in the same cycle as a sample does not affect that sample. It takes effect from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index: 0 to 3 are gains, 4 is control |
| cfg_wdata | input | 8 | Write data |
| in_valid | input | 1 | Input sample pair valid |
| in_left | input | 16 | Signed left input sample |
| in_right | input | 16 | Signed right input sample |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | 16 | Signed left output sample, saturated |
| out_right | output | 16 | Signed right output sample, saturated |

## Verification
The assertions assume that reset is held low from time zero for at least one clock edge. They also assume that every input is at a known level on each sampled edge, since the hold and copy properties compare registered state across edges. The bench drives every input at the falling edge from tasks, after setting each one to a defined value at time zero. It keeps cfg_we low except for single-cycle writes, so every apply and mute change falls on a known cycle relative to the samples around it.

// File: rtl/xmix_pkg.sv
package xmix_pkg;
  localparam int NUM_GAINS  = 4;
  localparam int CFG_ADDR_W = 3;

  // Slot order is decoded by the mixer lanes; keep it.
  typedef enum logic [CFG_ADDR_W-1:0] {
    SLOT_LL   = 3'd0,
    SLOT_LR   = 3'd1,
    SLOT_RR   = 3'd2,
    SLOT_RL   = 3'd3,
    SLOT_CTRL = 3'd4
  } cfg_slot_e;

  localparam int CTRL_MUTE_BIT  = 0;
  localparam int CTRL_APPLY_BIT = 5;
endpackage

// File: rtl/xmix_cfg_decode.sv
module xmix_cfg_decode
  import xmix_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_idx,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [NUM_GAINS-1:0]  gain_we,
  output logic [DATA_W-1:0]     gain_data,
  output logic                  ctrl_we,
  output logic                  apply_pulse,
  output logic                  mute_next
);
  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_sel
    assign gain_we[g] = cfg_we && (cfg_idx == CFG_ADDR_W'(g));
  end

  always_comb begin
    ctrl_we     = cfg_we && (cfg_idx == SLOT_CTRL);
    apply_pulse = ctrl_we && cfg_wdata[CTRL_APPLY_BIT];
    mute_next   = cfg_wdata[CTRL_MUTE_BIT];
    gain_data   = cfg_wdata;
  end
endmodule

// File: rtl/xmix_gain_bank.sv
module xmix_gain_bank
  import xmix_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_GAINS-1:0]               gain_we,
  input  logic [DATA_W-1:0]                  gain_data,
  input  logic                               apply_pulse,
  output logic [NUM_GAINS-1:0][DATA_W-1:0]   pend_gains,
  output logic [NUM_GAINS-1:0][DATA_W-1:0]   act_gains
);
  localparam logic [DATA_W-1:0] UNITY = DATA_W'(1 << FRAC_W);

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_slot
    localparam bit STRAIGHT = (g == int'(SLOT_LL)) || (g == int'(SLOT_RR));
    localparam logic [DATA_W-1:0] RST_V = STRAIGHT ? UNITY : '0;
    logic [DATA_W-1:0] pend_r;
    logic [DATA_W-1:0] act_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_r <= RST_V;
        act_r  <= RST_V;
      end else begin
        if (gain_we[g]) pend_r <= gain_data;
        if (apply_pulse) act_r <= pend_r;
      end
    end

    assign pend_gains[g] = pend_r;
    assign act_gains[g]  = act_r;
  end
endmodule

// File: rtl/xmix_mix_lane.sv
module xmix_mix_lane #(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 8,
  parameter int FRAC_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic                       mute,
  input  logic signed [SAMPLE_W-1:0] own_s,
  input  logic [GAIN_W-1:0]          own_g,
  input  logic signed [SAMPLE_W-1:0] cross_s,
  input  logic [GAIN_W-1:0]          cross_g,
  output logic signed [SAMPLE_W-1:0] y
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam longint MAX_I = (longint'(1) <<< (SAMPLE_W - 1)) - 1;
  localparam longint MIN_I = -(longint'(1) <<< (SAMPLE_W - 1));

  function automatic logic signed [PROD_W-1:0] scale_term(
      input logic signed [SAMPLE_W-1:0] s, input logic [GAIN_W-1:0] g);
    logic signed [PROD_W-1:0] se;
    logic signed [PROD_W-1:0] ge;
    se = PROD_W'(s);
    ge = $signed(PROD_W'({1'b0, g}));
    return se * ge;
  endfunction

  function automatic logic signed [SUM_W-1:0] shift_sum(
      input logic signed [PROD_W-1:0] t0, input logic signed [PROD_W-1:0] t1);
    logic signed [SUM_W-1:0] acc;
    acc = SUM_W'(t0) + SUM_W'(t1);
    return acc >>> FRAC_W;
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] clip(input logic signed [SUM_W-1:0] v);
    if (v > SUM_W'(MAX_I)) return SAMPLE_W'(MAX_I);
    if (v < SUM_W'(MIN_I)) return SAMPLE_W'(MIN_I);
    return v[SAMPLE_W-1:0];
  endfunction

  logic signed [SAMPLE_W-1:0] mixed;
  assign mixed = clip(shift_sum(scale_term(own_s, own_g), scale_term(cross_s, cross_g)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y <= '0;
    else if (take) y <= mute ? '0 : mixed;
  end
endmodule

// File: rtl/xmix_atten.sv
module xmix_atten
  import xmix_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 8,
  parameter int FRAC_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_ADDR_W-1:0]      cfg_idx,
  input  logic [GAIN_W-1:0]          cfg_wdata,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right
);
  logic [NUM_GAINS-1:0]             gain_we;
  logic [GAIN_W-1:0]                gain_data;
  logic                             ctrl_we;
  logic                             apply_evt;
  logic                             mute_next;
  logic                             mute_q;
  logic                             sample_evt;
  logic [NUM_GAINS-1:0][GAIN_W-1:0] pend_gains;
  logic [NUM_GAINS-1:0][GAIN_W-1:0] act_gains;

  assign sample_evt = in_valid;

  xmix_cfg_decode #(.DATA_W(GAIN_W)) dec_i (
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .gain_we     (gain_we),
    .gain_data   (gain_data),
    .ctrl_we     (ctrl_we),
    .apply_pulse (apply_evt),
    .mute_next   (mute_next)
  );

  xmix_gain_bank #(.DATA_W(GAIN_W), .FRAC_W(FRAC_W)) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gain_we     (gain_we),
    .gain_data   (gain_data),
    .apply_pulse (apply_evt),
    .pend_gains  (pend_gains),
    .act_gains   (act_gains)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mute_q <= 1'b0;
    else if (ctrl_we) mute_q <= mute_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= sample_evt;
  end

  xmix_mix_lane #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) lane_l_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (sample_evt),
    .mute    (mute_q),
    .own_s   (in_left),
    .own_g   (act_gains[SLOT_LL]),
    .cross_s (in_right),
    .cross_g (act_gains[SLOT_RL]),
    .y       (out_left)
  );

  xmix_mix_lane #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) lane_r_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (sample_evt),
    .mute    (mute_q),
    .own_s   (in_right),
    .own_g   (act_gains[SLOT_RR]),
    .cross_s (in_left),
    .cross_g (act_gains[SLOT_LR]),
    .y       (out_right)
  );
endmodule

// File: rtl/xmix_atten_chk.sv
module xmix_atten_chk
  import xmix_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             in_valid,
  input logic                             apply_evt,
  input logic                             mute_q,
  input logic [NUM_GAINS-1:0][GAIN_W-1:0] pend_gains,
  input logic [NUM_GAINS-1:0][GAIN_W-1:0] act_gains,
  input logic                             out_valid,
  input logic [SAMPLE_W-1:0]              out_left,
  input logic [SAMPLE_W-1:0]              out_right
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_left == '0 && out_right == '0));

  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_evt |=> $stable(act_gains));

  p_apply_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> act_gains == $past(pend_gains));

  p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_q) |=> (out_left == '0 && out_right == '0));

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));
endmodule

bind xmix_atten xmix_atten_chk #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .apply_evt  (apply_evt),
  .mute_q     (mute_q),
  .pend_gains (pend_gains),
  .act_gains  (act_gains),
  .out_valid  (out_valid),
  .out_left   (out_left),
  .out_right  (out_right)
);

// File: tb/xmix_atten_tb.sv
`timescale 1ns/1ps
module xmix_atten_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_left = '0;
  logic signed [15:0] in_right = '0;
  logic out_valid;
  logic signed [15:0] out_left;
  logic signed [15:0] out_right;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [7:0] m_pend [4];
  logic [7:0] m_act [4];
  bit m_mute;

  always #2.5 clk = ~clk;

  xmix_atten dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  function automatic int weigh(int a, int ga, int b, int gb);
    int s;
    s = (a * ga + b * gb) >>> 7;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_write(int idx, logic [7:0] d);
    if (idx < 4) m_pend[idx] = d;
    else if (idx == 4) begin
      if (d[5]) for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
      m_mute = d[0];
    end
  endtask

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(idx, d);
  endtask

  // Sends one pair and checks the registered result against the model.
  task automatic send(string req, int l, int r);
    int el, er;
    el = m_mute ? 0 : weigh(l, m_act[0], r, m_act[3]);
    er = m_mute ? 0 : weigh(r, m_act[2], l, m_act[1]);
    @(negedge clk);
    in_valid = 1'b1; in_left = 16'(l); in_right = 16'(r);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " left"}, int'(out_left), el);
    chk({req, " right"}, int'(out_right), er);
  endtask

  task automatic t_reset_r1;
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 left in reset", int'(out_left), 0);
    chk("R1 right in reset", int'(out_right), 0);
    send("R1 pass-through", 1000, -2000);
    chk("R1 left identity", int'(out_left), 1000);
    chk("R1 right identity", int'(out_right), -2000);
  endtask

  task automatic t_pending_r2;
    for (int i = 0; i < 4; i++) wr(i, 8'h40);
    send("R2 pending only", 1200, 600);
    chk("R2 left unchanged", int'(out_left), 1200);
  endtask

  task automatic t_apply_r3_r4;
    wr(4, 8'h20);
    send("R3 applied", 1000, 0);
    chk("R3 left half", int'(out_left), 500);
    wr(0, 8'h80); wr(1, 8'h20); wr(2, 8'h40); wr(3, 8'h10);
    wr(4, 8'h20);
    send("R4 slot map", 256, 1024);
    chk("R4 left", int'(out_left), 384);
    chk("R4 right", int'(out_right), 576);
    wr(0, 8'h00);
    wr(4, 8'h00);
    send("R3 pulse not stored", 256, 1024);
    chk("R3 left kept", int'(out_left), 384);
    wr(4, 8'h20);
    send("R3 later apply", 256, 1024);
    chk("R3 left new", int'(out_left), 128);
  endtask

  task automatic t_bad_idx_r4;
    wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    wr(4, 8'h20);
    send("R4 index 5-7 ignored", -700, 900);
  endtask

  task automatic t_floor_r5;
    wr(0, 8'h40); wr(3, 8'h00); wr(1, 8'h00); wr(2, 8'hC0);
    wr(4, 8'h20);
    send("R5 floor", -3, -5);
    chk("R5 left floor", int'(out_left), -2);
    chk("R5 right floor", int'(out_right), -8);
  endtask

  task automatic t_sat_r6;
    for (int i = 0; i < 4; i++) wr(i, 8'hFF);
    wr(4, 8'h20);
    send("R6 high clip", 32767, 32767);
    chk("R6 left max", int'(out_left), 32767);
    send("R6 low clip", -32768, -32768);
    chk("R6 right min", int'(out_right), -32768);
  endtask

  task automatic t_mute_r7;
    wr(0, 8'h80); wr(1, 8'h00); wr(2, 8'h80); wr(3, 8'h00);
    wr(4, 8'h21);
    send("R7 muted", 5000, -5000);
    chk("R7 left zero", int'(out_left), 0);
    wr(4, 8'h00);
    send("R7 unmuted", 5000, -5000);
    chk("R7 left back", int'(out_left), 5000);
  endtask

  task automatic t_reserved_r8;
    wr(0, 8'h10);
    wr(4, 8'hDE);
    send("R8 reserved bits", 3000, 100);
    chk("R8 left no apply", int'(out_left), 3000);
  endtask

  task automatic t_latency_r9;
    logic signed [15:0] held;
    send("R9 sample", 1234, 4321);
    held = out_left;
    @(negedge clk);
    chk("R9 valid drops", int'(out_valid), 0);
    chk("R9 left holds", int'(out_left), int'(held));
    in_left = 16'sd9999;
    @(negedge clk);
    chk("R9 idle input ignored", int'(out_left), int'(held));
  endtask

  task automatic t_same_cycle_r10;
    int el;
    wr(0, 8'h40);
    el = weigh(800, m_act[0], 0, m_act[3]);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_wdata = 8'h21;
    in_valid = 1'b1; in_left = 16'sd800; in_right = 16'sd0;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R10 same-cycle sample old gains", int'(out_left), el);
    model_write(4, 8'h21);
    send("R10 next sample muted", 800, 0);
    wr(4, 8'h00);
    send("R10 new gain", 800, 0);
    chk("R10 left new gain", int'(out_left), 400);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_pend[i] = (i == 0 || i == 2) ? 8'h80 : 8'h00;
      m_act[i] = m_pend[i];
    end
    m_mute = 0;
    repeat (3) @(negedge clk);
    t_reset_r1_pre();
    rst_n = 1'b1;
    t_reset_r1;
    t_pending_r2;
    t_apply_r3_r4;
    t_bad_idx_r4;
    t_floor_r5;
    t_sat_r6;
    t_mute_r7;
    t_reserved_r8;
    t_latency_r9;
    t_same_cycle_r10;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic t_reset_r1_pre;
    chk("R1 valid held in reset", int'(out_valid), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule